// File: doc/BRIEF.md
# Half-Bridge Gate Pattern Generator

This block turns a digital frequency command into the two complementary gate enables of a half-bridge: one for the low-side switch and one for the high-side switch. A phase counter runs at twice the switching rate. A toggle flop then assigns each phase to the low or the high side in turn. Each side is therefore on for half of the switching period, less the dead time that opens each of its phases.

Frequency is expressed as a phase length in clocks, so a shorter phase means a higher switching frequency. The command lowers the phase length from a programmed slow limit towards a programmed fast limit. Below its useful range the command leaves the output at the minimum frequency, and above it the output stays at the maximum frequency. The dead time is a fraction of the phase length, so it shrinks as the frequency rises.

An enable input and a force-off input stop the outputs at once. Every start, including the first after reset, waits a fixed number of clocks before the first gate pulse. A one-clock strobe marks the start of each phase.

Top module: `hb_gate_gen`

## Requirements
- R1: The phase length L, in clocks, is D = max(slow_len − freq_cmd, 0), then L = max(D, fast_len), then L is raised to at least 2. Consecutive strobes are exactly L clocks apart. `phase_stb_o` is high for exactly one clock, the first clock of each phase.
- R2: Phases alternate between low side and high side. The first phase after any start is a low-side phase. With constant inputs, both sides get phases of equal length. In a low-side phase only `gate_lo_o` may be high, and in a high-side phase only `gate_hi_o`.
- R3: `gate_lo_o` and `gate_hi_o` are never high in the same clock. For the first T clocks of every phase, both are low.
- R4: The dead time is T = min((dead_cfg × L) >> REF_SH, L − 1), with REF_SH = 6 by default. The active gate is high for the last L − T clocks of its phase, and it falls only at a phase boundary while the block runs.
- R5: The command, both limits and the dead-time setting are captured only on the clock that starts a phase. A change made partway through a phase leaves that phase's length and dead time as they were, and it takes effect from the next phase.
- R6: A high `force_off_i` or a low `enable_i` drives both gate enables low on the next clock. It also resets the side toggle, so the next start begins with a low-side phase.
- R7: After the clock edge that first samples `enable_i` high with `force_off_i` low, the block waits RESTART_CYC clocks (20 by default). The first phase strobe then appears RESTART_CYC + 1 clocks after the sampling edge, counted in outputs registered after each edge.
- R8: While reset is held, and right after it is released, both gate enables and the strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run request |
| force_off_i | input | 1 | Immediate stop; takes priority over enable |
| freq_cmd_i | input | CMD_W | Frequency command; a larger value gives a higher frequency |
| slow_len_i | input | PER_W | Phase length at the minimum frequency |
| fast_len_i | input | PER_W | Phase length at the maximum frequency |
| dead_cfg_i | input | DT_W | Dead-time setting, as a fraction of 2^REF_SH of the phase length |
| gate_lo_o | output | 1 | Low-side gate enable |
| gate_hi_o | output | 1 | High-side gate enable |
| phase_stb_o | output | 1 | One-clock strobe at the start of each phase |

## Verification
The bench drives commands beyond both clamp limits and a fast limit below two. A design that got these wrong would produce phases too long or too short, or strobes in back-to-back clocks. It uses dead-time settings of zero and of full scale. A design without saturation would then lose the on-time entirely, and one without scaling would keep the dead time constant across frequencies.

The bench changes the command in the middle of a phase. A design that samples the command continuously would stretch or cut that phase. It also forces the outputs off during a high-side phase. A design that does not reset the toggle would restart on the high side, and one that skips the restart wait would pulse too early.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } hbg_state_e;
endpackage

// File: rtl/hbg_rate.sv
module hbg_rate #(
    parameter int CMD_W = 12,
    parameter int PER_W = 10
) (
    input  logic [CMD_W-1:0] cmd_i,
    input  logic [PER_W-1:0] slow_len_i,
    input  logic [PER_W-1:0] fast_len_i,
    output logic [PER_W-1:0] len_o
);
    localparam int WW = (CMD_W > PER_W) ? CMD_W : PER_W;

    logic [WW-1:0]    slow_w;
    logic [WW-1:0]    cmd_w;
    logic [WW-1:0]    diff_w;
    logic [PER_W-1:0] len_c;

    always_comb begin
        slow_w = WW'(slow_len_i);
        cmd_w  = WW'(cmd_i);
        diff_w = (slow_w > cmd_w) ? (slow_w - cmd_w) : '0;
        if (diff_w < WW'(fast_len_i)) begin
            len_c = fast_len_i;
        end else begin
            len_c = PER_W'(diff_w);
        end
        if (len_c < PER_W'(2)) begin
            len_c = PER_W'(2);
        end
        len_o = len_c;
    end
endmodule

// File: rtl/hbg_dead.sv
module hbg_dead #(
    parameter int PER_W  = 10,
    parameter int DT_W   = 8,
    parameter int REF_SH = 6
) (
    input  logic [PER_W-1:0] len_i,
    input  logic [DT_W-1:0]  dead_cfg_i,
    output logic [PER_W-1:0] dead_o
);
    localparam int PW = DT_W + PER_W;

    logic [PW-1:0]    prod_w;
    logic [PW-1:0]    scaled_w;
    logic [PER_W-1:0] cap_w;

    always_comb begin
        prod_w   = PW'(dead_cfg_i) * PW'(len_i);
        scaled_w = prod_w >> REF_SH;
        cap_w    = len_i - PER_W'(1);
        dead_o   = (scaled_w > PW'(cap_w)) ? cap_w : PER_W'(scaled_w);
    end
endmodule

// File: rtl/hbg_seq.sv
module hbg_seq
    import hbg_pkg::*;
#(
    parameter int PER_W       = 10,
    parameter int RESTART_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             force_off_i,
    input  logic [PER_W-1:0] len_new_i,
    input  logic [PER_W-1:0] dead_new_i,
    output logic             gate_lo_o,
    output logic             gate_hi_o,
    output logic             phase_stb_o
);
    localparam int DLY_W = $clog2(RESTART_CYC + 1);

    typedef struct packed {
        hbg_state_e       state;
        logic [PER_W-1:0] cnt;
        logic             side;
        logic [PER_W-1:0] len;
        logic [PER_W-1:0] dead;
        logic [DLY_W-1:0] dly;
        logic             lo;
        logic             hi;
        logic             stb;
    } seq_t;

    seq_t seq_d, seq_q;
    logic on_d;

    always_comb begin
        seq_d     = seq_q;
        seq_d.stb = 1'b0;
        if (force_off_i || !enable_i) begin
            seq_d.state = ST_IDLE;
            seq_d.cnt   = '0;
            seq_d.side  = 1'b0;
            seq_d.dly   = '0;
        end else begin
            case (seq_q.state)
                ST_IDLE: begin
                    seq_d.state = ST_WAIT;
                    seq_d.dly   = '0;
                end
                ST_WAIT: begin
                    if (seq_q.dly == DLY_W'(RESTART_CYC - 1)) begin
                        seq_d.state = ST_RUN;
                        seq_d.cnt   = '0;
                        seq_d.side  = 1'b0;
                        seq_d.len   = len_new_i;
                        seq_d.dead  = dead_new_i;
                        seq_d.stb   = 1'b1;
                    end else begin
                        seq_d.dly = seq_q.dly + DLY_W'(1);
                    end
                end
                ST_RUN: begin
                    if (seq_q.cnt == seq_q.len - PER_W'(1)) begin
                        seq_d.cnt  = '0;
                        seq_d.side = ~seq_q.side;
                        seq_d.len  = len_new_i;
                        seq_d.dead = dead_new_i;
                        seq_d.stb  = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt + PER_W'(1);
                    end
                end
                default: seq_d.state = ST_IDLE;
            endcase
        end
        // both sides leave through one register stage: equal latency
        on_d     = (seq_d.state == ST_RUN) && (seq_d.cnt >= seq_d.dead);
        seq_d.lo = on_d && !seq_d.side;
        seq_d.hi = on_d && seq_d.side;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, cnt: '0, side: 1'b0, len: PER_W'(2),
                       dead: '0, dly: '0, lo: 1'b0, hi: 1'b0, stb: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign gate_lo_o   = seq_q.lo;
    assign gate_hi_o   = seq_q.hi;
    assign phase_stb_o = seq_q.stb;
endmodule

// File: rtl/hb_gate_gen.sv
module hb_gate_gen #(
    parameter int CMD_W       = 12,
    parameter int PER_W       = 10,
    parameter int DT_W        = 8,
    parameter int REF_SH      = 6,
    parameter int RESTART_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             force_off_i,
    input  logic [CMD_W-1:0] freq_cmd_i,
    input  logic [PER_W-1:0] slow_len_i,
    input  logic [PER_W-1:0] fast_len_i,
    input  logic [DT_W-1:0]  dead_cfg_i,
    output logic             gate_lo_o,
    output logic             gate_hi_o,
    output logic             phase_stb_o
);
    logic [PER_W-1:0] len_w;
    logic [PER_W-1:0] dead_w;

    hbg_rate #(.CMD_W(CMD_W), .PER_W(PER_W)) u_rate (
        .cmd_i      (freq_cmd_i),
        .slow_len_i (slow_len_i),
        .fast_len_i (fast_len_i),
        .len_o      (len_w)
    );

    hbg_dead #(.PER_W(PER_W), .DT_W(DT_W), .REF_SH(REF_SH)) u_dead (
        .len_i      (len_w),
        .dead_cfg_i (dead_cfg_i),
        .dead_o     (dead_w)
    );

    hbg_seq #(.PER_W(PER_W), .RESTART_CYC(RESTART_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .force_off_i (force_off_i),
        .len_new_i   (len_w),
        .dead_new_i  (dead_w),
        .gate_lo_o   (gate_lo_o),
        .gate_hi_o   (gate_hi_o),
        .phase_stb_o (phase_stb_o)
    );
endmodule

// File: rtl/hbg_checks.sv
module hbg_checks (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic force_off_i,
    input logic gate_lo_o,
    input logic gate_hi_o,
    input logic phase_stb_o
);
    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo_o && gate_hi_o));

    assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb_o |=> !phase_stb_o);

    assert_stop_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off_i || !enable_i) |=> (!gate_lo_o && !gate_hi_o));

    assert_lo_fall_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_lo_o) && $past(enable_i && !force_off_i)) |-> phase_stb_o);

    assert_hi_fall_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_hi_o) && $past(enable_i && !force_off_i)) |-> phase_stb_o);

    assert_stb_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb_o |-> $past(enable_i && !force_off_i));
endmodule

bind hb_gate_gen hbg_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .force_off_i (force_off_i),
    .gate_lo_o   (gate_lo_o),
    .gate_hi_o   (gate_hi_o),
    .phase_stb_o (phase_stb_o)
);

// File: tb/hb_gate_gen_test.sv
module hb_gate_gen_test;
    localparam int CMD_W = 12;
    localparam int PER_W = 10;
    localparam int DT_W  = 8;
    localparam int SH    = 6;
    localparam int RST_C = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic frc = 1'b0;
    logic [CMD_W-1:0] cmd = '0;
    logic [PER_W-1:0] slow = 10'd40;
    logic [PER_W-1:0] fast = 10'd10;
    logic [DT_W-1:0]  dt = '0;
    logic lo, hi, stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hb_gate_gen #(.CMD_W(CMD_W), .PER_W(PER_W), .DT_W(DT_W), .REF_SH(SH),
                  .RESTART_CYC(RST_C)) uut (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .force_off_i(frc),
        .freq_cmd_i(cmd), .slow_len_i(slow), .fast_len_i(fast),
        .dead_cfg_i(dt), .gate_lo_o(lo), .gate_hi_o(hi), .phase_stb_o(stb));

    function automatic int exp_len(int s, int f, int c);
        int d, l;
        d = (s > c) ? s - c : 0;
        l = (d < f) ? f : d;
        if (l < 2) l = 2;
        return l;
    endfunction

    function automatic int exp_dead(int d, int l);
        int s;
        s = (d * l) >> SH;
        return (s > l - 1) ? l - 1 : s;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic measure_phase(input int chg_at, input int new_cmd,
                                 output int len, output int lead,
                                 output int onl, output int onh, output int both);
        bit seen = 1'b0;
        len = 0; lead = 0; onl = 0; onh = 0; both = 0;
        do begin
            if (len == chg_at) cmd = CMD_W'(new_cmd);
            len++;
            if (lo) onl++;
            if (hi) onh++;
            if (lo && hi) both++;
            if (!lo && !hi && !seen) lead++;
            if (lo || hi) seen = 1'b1;
            @(negedge clk);
        end while (!stb && len < 4000);
    endtask

    task automatic check_phase(int side, int len, int lead, int onl, int onh,
                               int both, int l_exp, int d_exp);
        check(len == l_exp, "R1 phase length", len, l_exp);
        check(lead == d_exp, "R4 dead time", lead, d_exp);
        check(both == 0, "R3 overlap", both, 0);
        if (side == 0) begin
            check(onl == l_exp - d_exp, "R2 low-side on-time", onl, l_exp - d_exp);
            check(onh == 0, "R2 high side idle", onh, 0);
        end else begin
            check(onh == l_exp - d_exp, "R2 high-side on-time", onh, l_exp - d_exp);
            check(onl == 0, "R2 low side idle", onl, 0);
        end
    endtask

    task automatic wait_first_strobe();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!stb && n < 1000);
        check(n == RST_C + 1, "R7 restart delay", n, RST_C + 1);
    endtask

    task automatic start_case(int s, int f, int c, int d);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!lo && !hi, "R6 disable stops gates", int'(lo) + int'(hi), 0);
        slow = PER_W'(s); fast = PER_W'(f); cmd = CMD_W'(c); dt = DT_W'(d);
        @(negedge clk);
        en = 1'b1;
        wait_first_strobe();
    endtask

    task automatic run_case(int s, int f, int c, int d, int nph);
        int l_e, d_e, len, lead, onl, onh, both;
        l_e = exp_len(s, f, c);
        d_e = exp_dead(d, l_e);
        start_case(s, f, c, d);
        for (int i = 0; i < nph; i++) begin
            measure_phase(-1, 0, len, lead, onl, onh, both);
            check_phase(i % 2, len, lead, onl, onh, both, l_e, d_e);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int len, lead, onl, onh, both, s, f, c, d, n;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(!lo && !hi && !stb, "R8 during reset", int'(lo) + int'(hi) + int'(stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!lo && !hi && !stb, "R8 after reset", int'(lo) + int'(hi) + int'(stb), 0);

        // directed cases
        run_case(40, 10, 0, 32, 4);     // R1 slow limit, R4 mid dead time
        run_case(40, 10, 300, 32, 3);   // R1 command above range: fast limit
        run_case(40, 10, 15, 64, 3);    // R1 linear region
        run_case(30, 1, 200, 200, 3);   // R1 floor of 2, R4 cap at L-1
        run_case(50, 8, 0, 255, 2);     // R4 saturation to L-1
        run_case(25, 4, 3, 0, 3);       // R4 zero dead time

        // R5: command change partway through a phase
        start_case(60, 5, 0, 16);
        measure_phase(5, 30, len, lead, onl, onh, both);
        check_phase(0, len, lead, onl, onh, both, 60, exp_dead(16, 60));
        measure_phase(-1, 0, len, lead, onl, onh, both);
        check(len == 30, "R5 new length next phase", len, 30);
        check(lead == exp_dead(16, 30), "R5 new dead time next phase", lead, exp_dead(16, 30));

        // R6: force-off during a high-side phase
        n = 0;
        while (!hi && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(hi, "R6 reached high side", int'(hi), 1);
        frc = 1'b1;
        @(negedge clk);
        check(!lo && !hi, "R6 force-off next clock", int'(lo) + int'(hi), 0);
        repeat (5) @(negedge clk);
        check(!lo && !hi && !stb, "R6 held off", int'(lo) + int'(hi) + int'(stb), 0);
        frc = 1'b0;
        wait_first_strobe();
        measure_phase(-1, 0, len, lead, onl, onh, both);
        check(onl > 0 && onh == 0, "R6 restart on low side", onh, 0);

        // random cases
        for (int k = 0; k < 10; k++) begin
            s = 10 + int'($urandom % 200);
            f = 1 + int'($urandom % s);
            c = int'($urandom % 256);
            d = int'($urandom % 256);
            run_case(s, f, c, d, 3);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule